// File: doc/BRIEF.md
# Floating-Point Multiplier Register Interface

This block is an AXI4-Lite slave that lets a processor drive an attached single-precision multiplier. The bus writes a control word and two operand words; the operand words are presented without interruption on two 32-bit output ports, and bit 0 of the control word is brought out as a start/enable line. A fourth word is read-only and returns the multiplier's product, which enters on an input port. The arithmetic itself lies outside this block.

The write channel is served by a three-state machine. The states are idle (ready for an address), data (ready for write data) and response (the write response is held). The read channel uses a two-state machine with an idle state and a data state that holds read data until it is accepted. Each write honours its byte strobes. Every transfer completes with an OKAY response. The asynchronous active-low bus reset is released synchronously inside the block. Only byte-address bits 3:2 reach the block, because only those bits decode a register.

Top module: `fmul_axil_regs`

## Requirements
- R1: After reset the control, operand A and operand B words are zero, `opa_o`, `opb_o` and `go_o` are zero, `awready` and `arready` are high, and `bvalid` and `rvalid` are low.
- R2: The word index (byte-address bits 3:2) selects 0 = control, 1 = operand A, 2 = operand B, 3 = product. Reads of indices 0, 1 and 2 return the last values written.
- R3: A write changes byte lane k (bits 8k+7:8k) of the selected word only when `wstrb[k]` is 1. All other lanes keep their value.
- R4: A write to index 3 changes no stored word. It still completes with a write response.
- R5: `opa_o` and `opb_o` equal the operand A and operand B words at all times, and `go_o` equals bit 0 of the control word.
- R6: `awready` is high only when the write machine is idle. `wready` is high only after an address has been accepted and never in the same cycle as `awready`. Write data offered together with the address is taken one cycle later. `bvalid` stays high until `bready` is seen, and the machine then returns to idle.
- R7: `arready` is high only when the read machine is idle. Once `rvalid` rises, `rvalid` and `rdata` stay unchanged until `rready` is seen, even if the product input changes. After that the machine returns to idle.
- R8: `bresp` and `rresp` are 2'b00 (OKAY) for every transfer.
- R9: A read of index 3 returns the value of `prod_i` in the cycle the read address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| awaddr | input | 2 | Write address, byte-address bits 3:2 |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | 2 | Read address, byte-address bits 3:2 |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| prod_i | input | 32 | Product from the multiplier |
| opa_o | output | 32 | Operand A to the multiplier |
| opb_o | output | 32 | Operand B to the multiplier |
| go_o | output | 1 | Control bit 0, start/enable to the multiplier |

## Verification
The embedded assertions check the handshake rules on every cycle:
- the mutual exclusion of the write-machine ready and valid lines,
- the holding of `bvalid` and of `rvalid`/`rdata` until they are accepted,
- the return to idle after each accepted response,
- that lanes with a clear strobe and writes to the product index leave storage untouched.

Only the bench scenarios can show the register map and the byte-lane merging against an independent model, together with the operand and enable ports tracking each write and a product read reflecting the value at address acceptance. They cover every index with all sixteen strobe patterns, varied write-data gaps and response delays, and a product change while a read waits.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
  localparam int ADDR_LSB = 2;
  localparam int IDX_W    = 2;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int NUM_RW   = NUM_REGS - 1;

  localparam logic [IDX_W-1:0] IDX_CTRL = 2'd0;
  localparam logic [IDX_W-1:0] IDX_OPA  = 2'd1;
  localparam logic [IDX_W-1:0] IDX_OPB  = 2'd2;
  localparam logic [IDX_W-1:0] IDX_PROD = 2'd3;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_DATA = 2'd1,
    WR_RESP = 2'd2
  } wr_state_e;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_DATA = 1'b1
  } rd_state_e;
endpackage

// File: rtl/fmr_rst_sync.sv
module fmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/fmr_wr_fsm.sv
module fmr_wr_fsm
  import fmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] awidx,
  input  logic             awvalid,
  output logic             awready,
  input  logic             wvalid,
  output logic             wready,
  output logic             bvalid,
  input  logic             bready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);
  wr_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             aw_fire;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WR_IDLE: if (awvalid) state_d = WR_DATA;
      WR_DATA: if (wvalid)  state_d = WR_RESP;
      WR_RESP: if (bready)  state_d = WR_IDLE;
      default:              state_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WR_IDLE;
    else        state_q <= state_d;
  end

  assign aw_fire = awvalid && awready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (aw_fire) idx_q <= awidx;
  end

  assign awready = (state_q == WR_IDLE);
  assign wready  = (state_q == WR_DATA);
  assign bvalid  = (state_q == WR_RESP);
  assign wr_en   = wvalid && wready;
  assign wr_idx  = idx_q;

  // R6: response held until accepted
  a_r6_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  // R6: data phase only follows an accepted address or itself
  a_r6_w_after_aw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wready) |-> $past(aw_fire));
  // R6: a response only follows a data beat
  a_r6_b_after_w: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> $past(wr_en));
  // R6: accepted response returns the machine to idle
  a_r6_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && bready |=> awready && !bvalid);
endmodule

// File: rtl/fmr_rd_fsm.sv
module fmr_rd_fsm
  import fmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [IDX_W-1:0]                  aridx,
  input  logic                              arvalid,
  output logic                              arready,
  output logic                              rvalid,
  input  logic                              rready,
  output logic [DATA_W-1:0]                 rdata,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]   words
);
  rd_state_e         state_q, state_d;
  logic [DATA_W-1:0] rdata_q;
  logic              ar_fire;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RD_IDLE: if (arvalid) state_d = RD_DATA;
      RD_DATA: if (rready)  state_d = RD_IDLE;
      default:              state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RD_IDLE;
    else        state_q <= state_d;
  end

  assign ar_fire = arvalid && arready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (ar_fire) rdata_q <= words[aridx];
  end

  assign arready = (state_q == RD_IDLE);
  assign rvalid  = (state_q == RD_DATA);
  assign rdata   = rdata_q;

  // R7: data and valid held until accepted
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R7: accepted data returns the machine to idle
  a_r7_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && rready |=> arready && !rvalid);
  // R7: valid only rises after an accepted address
  a_r7_valid_after_ar: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $past(ar_fire));
endmodule

// File: rtl/fmr_regfile.sv
module fmr_regfile
  import fmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [DATA_W-1:0]               wdata,
  input  logic [DATA_W/8-1:0]             wstrb,
  output logic [NUM_RW-1:0][DATA_W-1:0]   regs
);
  localparam int LANES = DATA_W / 8;

  logic [NUM_RW-1:0][DATA_W-1:0] regs_q;

  for (genvar r = 0; r < NUM_RW; r++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(r));
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic lane_en;
      assign lane_en = sel && wstrb[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       regs_q[r][8*b +: 8] <= '0;
        else if (lane_en) regs_q[r][8*b +: 8] <= wdata[8*b +: 8];
      end

      // R3: a lane with a clear strobe keeps its value
      a_r3_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wstrb[b] |=> $stable(regs_q[r][8*b +: 8]));
    end
  end

  assign regs = regs_q;

  // R4: writes aimed at the product index leave storage unchanged
  a_r4_prod_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx == IDX_PROD |=> $stable(regs_q));
endmodule

// File: rtl/fmul_axil_regs.sv
module fmul_axil_regs
  import fmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic                        aclk,
  input  logic                        aresetn,
  input  logic [ADDR_LSB+IDX_W-1:ADDR_LSB] awaddr,
  input  logic                        awvalid,
  output logic                        awready,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [STRB_W-1:0]           wstrb,
  input  logic                        wvalid,
  output logic                        wready,
  output logic [1:0]                  bresp,
  output logic                        bvalid,
  input  logic                        bready,
  input  logic [ADDR_LSB+IDX_W-1:ADDR_LSB] araddr,
  input  logic                        arvalid,
  output logic                        arready,
  output logic [DATA_W-1:0]           rdata,
  output logic [1:0]                  rresp,
  output logic                        rvalid,
  input  logic                        rready,
  input  logic [DATA_W-1:0]           prod_i,
  output logic [DATA_W-1:0]           opa_o,
  output logic [DATA_W-1:0]           opb_o,
  output logic                        go_o
);
  logic                            rst_n;
  logic                            wr_en;
  logic [IDX_W-1:0]                wr_idx;
  logic [NUM_RW-1:0][DATA_W-1:0]   regs;
  logic [NUM_REGS-1:0][DATA_W-1:0] words;

  fmr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (aclk),
    .arst_n (aresetn),
    .rst_n  (rst_n)
  );

  fmr_wr_fsm u_wr (
    .clk     (aclk),
    .rst_n   (rst_n),
    .awidx   (awaddr),
    .awvalid (awvalid),
    .awready (awready),
    .wvalid  (wvalid),
    .wready  (wready),
    .bvalid  (bvalid),
    .bready  (bready),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx)
  );

  fmr_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk    (aclk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wdata  (wdata),
    .wstrb  (wstrb),
    .regs   (regs)
  );

  assign words[IDX_CTRL] = regs[IDX_CTRL];
  assign words[IDX_OPA]  = regs[IDX_OPA];
  assign words[IDX_OPB]  = regs[IDX_OPB];
  assign words[IDX_PROD] = prod_i;

  fmr_rd_fsm #(.DATA_W(DATA_W)) u_rd (
    .clk     (aclk),
    .rst_n   (rst_n),
    .aridx   (araddr),
    .arvalid (arvalid),
    .arready (arready),
    .rvalid  (rvalid),
    .rready  (rready),
    .rdata   (rdata),
    .words   (words)
  );

  assign bresp = RESP_OKAY;
  assign rresp = RESP_OKAY;
  assign opa_o = regs[IDX_OPA];
  assign opb_o = regs[IDX_OPB];
  assign go_o  = regs[IDX_CTRL][0];

  // R6: address and data readiness never overlap
  a_r6_aw_w_exclusive: assert property (@(posedge aclk) disable iff (!rst_n)
    !(awready && wready));
  // R7: address readiness never overlaps pending read data
  a_r7_ar_r_exclusive: assert property (@(posedge aclk) disable iff (!rst_n)
    !(arready && rvalid));
  // R5: operand A port only moves on a data beat
  a_r5_opa_quiet: assert property (@(posedge aclk) disable iff (!rst_n)
    !wr_en |=> $stable(opa_o));
endmodule

// File: tb/sim_fmul_axil_regs.sv
module sim_fmul_axil_regs;
  logic        aclk = 1'b0;
  logic        aresetn = 1'b0;
  logic [3:2]  awaddr = '0;
  logic        awvalid = 1'b0;
  logic        awready;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        wvalid = 1'b0;
  logic        wready;
  logic [1:0]  bresp;
  logic        bvalid;
  logic        bready = 1'b0;
  logic [3:2]  araddr = '0;
  logic        arvalid = 1'b0;
  logic        arready;
  logic [31:0] rdata;
  logic [1:0]  rresp;
  logic        rvalid;
  logic        rready = 1'b0;
  logic [31:0] prod_q;
  logic [31:0] tweak = '0;
  logic [31:0] prod_i;
  logic [31:0] opa_o, opb_o;
  logic        go_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_r [3];

  always #2 aclk = ~aclk;

  fmul_axil_regs u0 (
    .aclk(aclk), .aresetn(aresetn),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .prod_i(prod_i), .opa_o(opa_o), .opb_o(opb_o), .go_o(go_o)
  );

  function automatic logic [31:0] fmodel(input logic [31:0] a, input logic [31:0] b);
    return {a[15:0] ^ b[31:16], a[31:16] + b[15:0]};
  endfunction

  always_ff @(posedge aclk) prod_q <= fmodel(opa_o, opb_o);
  assign prod_i = prod_q ^ tweak;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic chk_ports();
    chk(opa_o == exp_r[1], "R5 opa", opa_o, exp_r[1]);
    chk(opb_o == exp_r[2], "R5 opb", opb_o, exp_r[2]);
    chk(go_o == exp_r[0][0], "R5 go", {31'd0, go_o}, {31'd0, exp_r[0][0]});
  endtask

  task automatic do_write(input logic [1:0] idx, input logic [31:0] d,
                          input logic [3:0] s, input int wgap, input int bdly);
    @(negedge aclk);
    awaddr = idx; awvalid = 1'b1; wdata = d; wstrb = s; wvalid = (wgap == 0);
    while (!awready) @(negedge aclk);
    chk(!wready, "R6 wready with awready", {31'd0, wready}, 32'd0);
    @(negedge aclk);
    awvalid = 1'b0;
    for (int g = 0; g < wgap; g++) begin
      chk(wready && !bvalid && !awready, "R6 data wait", {29'd0, awready, wready, bvalid}, 32'd2);
      @(negedge aclk);
    end
    wvalid = 1'b1;
    @(negedge aclk);
    wvalid = 1'b0;
    chk(bvalid, "R6 bvalid", {31'd0, bvalid}, 32'd1);
    chk(bresp == 2'b00, "R8 bresp", {30'd0, bresp}, 32'd0);
    for (int k = 0; k < 4; k++)
      if (s[k] && idx != 2'd3) exp_r[idx][8*k +: 8] = d[8*k +: 8];
    chk_ports();
    for (int g = 0; g < bdly; g++) begin
      @(negedge aclk);
      chk(bvalid, "R6 bvalid hold", {31'd0, bvalid}, 32'd1);
    end
    bready = 1'b1;
    @(negedge aclk);
    bready = 1'b0;
    chk(!bvalid && awready, "R6 back to idle", {30'd0, bvalid, awready}, 32'd1);
  endtask

  task automatic do_read(input logic [1:0] idx, input int rdly, input bit flip);
    logic [31:0] expv, first;
    @(negedge aclk);
    araddr = idx; arvalid = 1'b1;
    while (!arready) @(negedge aclk);
    expv = (idx == 2'd3) ? (fmodel(exp_r[1], exp_r[2]) ^ tweak) : exp_r[idx];
    @(negedge aclk);
    arvalid = 1'b0;
    chk(rvalid, "R7 rvalid", {31'd0, rvalid}, 32'd1);
    chk(rdata == expv, (idx == 2'd3) ? "R9 product read" : "R2 readback", rdata, expv);
    chk(rresp == 2'b00, "R8 rresp", {30'd0, rresp}, 32'd0);
    first = rdata;
    for (int g = 0; g < rdly; g++) begin
      if (flip && g == 0) tweak = ~tweak;
      @(negedge aclk);
      chk(rvalid && rdata == first && !arready, "R7 hold", rdata, first);
    end
    rready = 1'b1;
    @(negedge aclk);
    rready = 1'b0;
    chk(!rvalid && arready, "R7 back to idle", {30'd0, rvalid, arready}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) exp_r[i] = '0;
    repeat (3) @(negedge aclk);
    aresetn = 1'b1;
    repeat (4) @(negedge aclk);
    // R1: reset state
    chk(awready && arready && !bvalid && !rvalid, "R1 handshake lines",
        {28'd0, awready, arready, bvalid, rvalid}, 32'hC);
    chk_ports();
    for (int i = 0; i < 3; i++) do_read(2'(i), 0, 1'b0);
    do_read(2'd3, 0, 1'b0);

    // R2 R3 R4: sweep every index against every strobe pattern
    for (int idx = 0; idx < 4; idx++) begin
      for (int s = 0; s < 16; s++) begin
        logic [31:0] d;
        d = (32'h1F2E3D4C ^ (32'(idx) * 32'h0F1E2D3C)) + 32'(s) * 32'h01030507;
        do_write(2'(idx), d, 4'(s), s % 3, s % 2);
        do_read(2'(idx), s % 4, 1'b0);
        if (idx == 3) for (int r = 0; r < 3; r++) do_read(2'(r), 0, 1'b0);
      end
    end

    // R9 R7: product changes while a read waits for acceptance
    do_write(2'd1, 32'h3FC00000, 4'hF, 0, 0);
    do_write(2'd2, 32'hC0200000, 4'hF, 1, 0);
    do_read(2'd3, 4, 1'b1);
    do_read(2'd3, 0, 1'b0);
    // R5: control bit 0 toggling
    do_write(2'd0, 32'h00000001, 4'h1, 0, 0);
    do_write(2'd0, 32'hFFFFFFFE, 4'hF, 2, 3);
    do_read(2'd0, 1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge aclk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule